// File: doc/BRIEF.md
# Single-Channel Peripheral/Memory Transfer Engine

This block moves a programmed number of data elements between a peripheral address and a memory address. Software programs it while it is stopped, through a small word-addressed register port. The registers hold the two base addresses, the element count and a control word: a separate increment enable for each side, element size, direction, wrap-around (circular) operation and interrupt enable. The same control word carries the run bit. Once running, the engine makes every element transfer itself, with no processor help.

Each element is moved as one single-beat read on a valid/ready request port, then one write of the returned data to the other side. A level-sensitive request line from the peripheral sets the pace: a new element starts only while that line is high and the previous write has been accepted. When the last element of the count is written, a completion flag is set. It raises the interrupt output if the interrupt is enabled. In circular mode the engine reloads its addresses and count and goes on by itself. Otherwise it stops and clears its run bit.

Top module: `dma_channel`

## Requirements
- R1: After reset every readable register (word offsets 0 to 5) reads zero, `irq` is low and `m_valid` is low.
- R2: Register map by word offset: 0 control, 1 status (bit 0 = completion flag), 2 peripheral base, 3 memory base, 4 element count, 5 elements remaining (read-only). Control bits: 0 run, 1 peripheral-side increment, 2 memory-side increment, 4:3 size, 5 circular, 6 direction, 7 interrupt enable. Written values read back, and starting the channel loads the remaining count from the element count.
- R3: Each element is one read request (`m_write`=0) at the source address, then one write request (`m_write`=1) at the destination address that carries the read response data. A request holds its valid, address and type until it is accepted. A read request is only issued after a cycle in which the channel was running and `per_req` was high.
- R4: Direction 0 reads from the peripheral side and writes to the memory side; direction 1 does the reverse. Each side's address advances after every completed element only when that side's increment bit is set.
- R5: Size code 0, 1 or 2 selects 1, 2 or 4 bytes. The address step equals the element size, and `m_size` carries the size code on every request.
- R6: In non-circular mode, completing the last element clears the run bit, sets the completion flag and leaves zero elements remaining.
- R7: In circular mode, completing the last element sets the completion flag, reloads both addresses and the remaining count from the programmed values, and the channel keeps running.
- R8: `irq` is high exactly when the completion flag and the interrupt enable are both set.
- R9: Writing 1 to status bit 0 clears the completion flag. If the same cycle completes a count, the flag ends up set.
- R10: A write that sets the run bit has no effect while the completion flag is set.
- R11: While running, writes to offsets 2, 3 and 4 and to the control fields are ignored. A control write with bit 0 low stops the channel; an element already in flight still completes.
- R12: Setting the run bit with an element count of zero leaves the channel stopped and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| per_req | input | 1 | Peripheral transfer request (level) |
| m_valid | output | 1 | Request valid |
| m_ready | input | 1 | Request accepted |
| m_write | output | 1 | 1 = write request, 0 = read request |
| m_addr | output | 32 | Request byte address |
| m_size | output | 2 | Element size code |
| m_wdata | output | 32 | Write data |
| m_rsp_valid | input | 1 | Read response valid |
| m_rsp_data | input | 32 | Read response data |
| irq | output | 1 | Transfer-complete interrupt |

## Verification
Two functions can fall in the same cycle. A software write-one-to-clear of the completion flag can meet the hardware setting of that flag when a circular lap ends. A stop or enable write to the control word can meet a non-circular completion that clears the run bit. The bench provokes the first by writing the clear on every cycle while a short circular transfer runs under random bus stalls, so each lap end meets a clear. The behavioural model lets the set win, and `irq` and the status word are compared against it on every clock.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD    = 2'd1,
    ST_RWAIT = 2'd2,
    ST_WR    = 2'd3
  } dma_state_e;

  // control word bits 7:1 (bit 0 is the run bit, held separately)
  typedef struct packed {
    logic       irq_en;
    logic       dir;
    logic       circ;
    logic [1:0] size;
    logic       mem_inc;
    logic       per_inc;
  } dma_cfg_t;

  localparam int CFG_W       = $bits(dma_cfg_t);
  localparam int REG_CTRL    = 0;
  localparam int REG_STAT    = 1;
  localparam int REG_PBASE   = 2;
  localparam int REG_MBASE   = 3;
  localparam int REG_COUNT   = 4;
  localparam int REG_REMAIN  = 5;
  localparam int CTRL_RUN    = 0;
  localparam int STAT_DONE   = 0;

  function automatic logic [2:0] step_of(input logic [1:0] size);
    case (size)
      2'd0:    step_of = 3'd1;
      2'd1:    step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic           fin_i,
  input  logic [CW-1:0]  rem_i,
  output logic           en_o,
  output logic           start_o,
  output logic           done_o,
  output dma_cfg_t       cfg_o,
  output logic [AW-1:0]  pbase_o,
  output logic [AW-1:0]  mbase_o,
  output logic [CW-1:0]  count_o
);

  logic          en_q, en_d, done_q, done_d;
  dma_cfg_t      cfg_q;
  logic [AW-1:0] pbase_q, mbase_q;
  logic [CW-1:0] count_q;
  logic          wr_ctrl, wr_stat, wr_pb, wr_mb, wr_cnt;
  logic          cfg_ce, pb_ce, mb_ce, cnt_ce, start;

  // next-state
  always_comb begin
    wr_ctrl = cfg_we && (cfg_addr == RAW'(REG_CTRL));
    wr_stat = cfg_we && (cfg_addr == RAW'(REG_STAT));
    wr_pb   = cfg_we && (cfg_addr == RAW'(REG_PBASE));
    wr_mb   = cfg_we && (cfg_addr == RAW'(REG_MBASE));
    wr_cnt  = cfg_we && (cfg_addr == RAW'(REG_COUNT));
    cfg_ce  = wr_ctrl && !en_q;
    pb_ce   = wr_pb   && !en_q;
    mb_ce   = wr_mb   && !en_q;
    cnt_ce  = wr_cnt  && !en_q;
    start   = cfg_ce && cfg_wdata[CTRL_RUN] && !done_q && (count_q != '0);

    en_d = en_q;
    if (start)
      en_d = 1'b1;
    else if (wr_ctrl && en_q && !cfg_wdata[CTRL_RUN])
      en_d = 1'b0;
    if (fin_i && !cfg_q.circ)
      en_d = 1'b0;

    done_d = done_q;
    if (wr_stat && cfg_wdata[STAT_DONE])
      done_d = 1'b0;
    if (fin_i)
      done_d = 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      cfg_q   <= '0;
      pbase_q <= '0;
      mbase_q <= '0;
      count_q <= '0;
    end else begin
      en_q   <= en_d;
      done_q <= done_d;
      if (cfg_ce) cfg_q   <= cfg_wdata[CFG_W:1];
      if (pb_ce)  pbase_q <= cfg_wdata[AW-1:0];
      if (mb_ce)  mbase_q <= cfg_wdata[AW-1:0];
      if (cnt_ce) count_q <= cfg_wdata[CW-1:0];
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RAW'(REG_CTRL):   cfg_rdata[CFG_W:0] = {cfg_q, en_q};
      RAW'(REG_STAT):   cfg_rdata[STAT_DONE] = done_q;
      RAW'(REG_PBASE):  cfg_rdata[AW-1:0] = pbase_q;
      RAW'(REG_MBASE):  cfg_rdata[AW-1:0] = mbase_q;
      RAW'(REG_COUNT):  cfg_rdata[CW-1:0] = count_q;
      RAW'(REG_REMAIN): cfg_rdata[CW-1:0] = rem_i;
      default:          cfg_rdata = '0;
    endcase
  end

  assign en_o    = en_q;
  assign start_o = start;
  assign done_o  = done_q;
  assign cfg_o   = cfg_q;
  assign pbase_o = pbase_q;
  assign mbase_o = mbase_q;
  assign count_o = count_q;

endmodule

// File: rtl/dma_ptr.sv
module dma_ptr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          inc_i,
  input  logic [2:0]    step_i,
  output logic [AW-1:0] cur_o
);

  logic [AW-1:0] cur_q, cur_d;
  logic          cur_ce;

  always_comb begin
    cur_ce = load_i || (adv_i && inc_i);
    cur_d  = load_i ? base_i : (cur_q + AW'(step_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_q <= '0;
    else if (cur_ce)
      cur_q <= cur_d;
  end

  assign cur_o = cur_q;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          per_req_i,
  input  dma_cfg_t      cfg_i,
  input  logic [CW-1:0] count_i,
  input  logic [AW-1:0] pcur_i,
  input  logic [AW-1:0] mcur_i,
  input  logic          m_ready_i,
  input  logic          m_rsp_valid_i,
  input  logic [DW-1:0] m_rsp_data_i,
  output logic          m_valid_o,
  output logic          m_write_o,
  output logic [AW-1:0] m_addr_o,
  output logic [1:0]    m_size_o,
  output logic [DW-1:0] m_wdata_o,
  output logic          elem_done_o,
  output logic          fin_o,
  output logic          reload_o,
  output logic [CW-1:0] rem_o
);

  dma_state_e    state_q, state_d;
  logic [DW-1:0] buf_q;
  logic [CW-1:0] rem_q, rem_d;
  logic          rem_ld, rem_ce, buf_ce;
  logic          elem_done, fin, reload;
  logic [AW-1:0] src_addr, dst_addr;

  // next-state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (en_i && per_req_i) state_d = ST_RD;
      ST_RD:    if (m_ready_i)         state_d = ST_RWAIT;
      ST_RWAIT: if (m_rsp_valid_i)     state_d = ST_WR;
      ST_WR:    if (m_ready_i)         state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase

    elem_done = (state_q == ST_WR) && m_ready_i;
    fin       = elem_done && (rem_q == CW'(1));
    reload    = fin && cfg_i.circ;
    rem_ld    = start_i || reload;
    rem_ce    = rem_ld || elem_done;
    rem_d     = rem_ld ? count_i : (rem_q - CW'(1));
    buf_ce    = (state_q == ST_RWAIT) && m_rsp_valid_i;

    src_addr  = cfg_i.dir ? mcur_i : pcur_i;
    dst_addr  = cfg_i.dir ? pcur_i : mcur_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      buf_q   <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      if (buf_ce) buf_q <= m_rsp_data_i;
      if (rem_ce) rem_q <= rem_d;
    end
  end

  assign m_valid_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign m_write_o   = (state_q == ST_WR);
  assign m_addr_o    = (state_q == ST_WR) ? dst_addr : src_addr;
  assign m_size_o    = cfg_i.size;
  assign m_wdata_o   = buf_q;
  assign elem_done_o = elem_done;
  assign fin_o       = fin;
  assign reload_o    = reload;
  assign rem_o       = rem_q;

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic           per_req,
  output logic           m_valid,
  input  logic           m_ready,
  output logic           m_write,
  output logic [AW-1:0]  m_addr,
  output logic [1:0]     m_size,
  output logic [DW-1:0]  m_wdata,
  input  logic           m_rsp_valid,
  input  logic [DW-1:0]  m_rsp_data,
  output logic           irq
);

  localparam int NSIDE = 2;  // 0: peripheral side, 1: memory side

  logic [1:0]    rst_pipe;
  logic          rst_n_s;
  logic          en, start, done, fin, reload, elem_done;
  dma_cfg_t      cfg;
  logic [AW-1:0] pbase, mbase;
  logic [CW-1:0] count_cfg, rem;
  logic [2:0]    step;
  logic [AW-1:0] base_v [NSIDE];
  logic [AW-1:0] cur_v  [NSIDE];
  logic          inc_v  [NSIDE];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  dma_regs #(.AW(AW), .DW(DW), .CW(CW), .RAW(RAW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .fin_i     (fin),
    .rem_i     (rem),
    .en_o      (en),
    .start_o   (start),
    .done_o    (done),
    .cfg_o     (cfg),
    .pbase_o   (pbase),
    .mbase_o   (mbase),
    .count_o   (count_cfg)
  );

  assign step      = step_of(cfg.size);
  assign base_v[0] = pbase;
  assign base_v[1] = mbase;
  assign inc_v[0]  = cfg.per_inc;
  assign inc_v[1]  = cfg.mem_inc;

  for (genvar g = 0; g < NSIDE; g++) begin : g_ptr
    dma_ptr #(.AW(AW)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .load_i (start || reload),
      .base_i (base_v[g]),
      .adv_i  (elem_done),
      .inc_i  (inc_v[g]),
      .step_i (step),
      .cur_o  (cur_v[g])
    );
  end

  dma_engine #(.AW(AW), .DW(DW), .CW(CW)) u_eng (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .en_i          (en),
    .start_i       (start),
    .per_req_i     (per_req),
    .cfg_i         (cfg),
    .count_i       (count_cfg),
    .pcur_i        (cur_v[0]),
    .mcur_i        (cur_v[1]),
    .m_ready_i     (m_ready),
    .m_rsp_valid_i (m_rsp_valid),
    .m_rsp_data_i  (m_rsp_data),
    .m_valid_o     (m_valid),
    .m_write_o     (m_write),
    .m_addr_o      (m_addr),
    .m_size_o      (m_size),
    .m_wdata_o     (m_wdata),
    .elem_done_o   (elem_done),
    .fin_o         (fin),
    .reload_o      (reload),
    .rem_o         (rem)
  );

  assign irq = done && cfg.irq_en;

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int RAW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           m_valid,
  input logic           m_ready,
  input logic           m_write,
  input logic [AW-1:0]  m_addr,
  input logic           cfg_we,
  input logic [RAW-1:0] cfg_addr,
  input logic [DW-1:0]  cfg_wdata,
  input logic           en,
  input logic           done,
  input logic [AW-1:0]  pbase,
  input logic [AW-1:0]  mbase,
  input logic [CW-1:0]  count
);

  assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)));

  assert_read_when_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(m_valid) && !m_write) |-> $past(en));

  assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> ($stable(pbase) && $stable(mbase) && $stable(count)));

  assert_flag_clear_by_sw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(cfg_we && (cfg_addr == RAW'(1)) && cfg_wdata[0]));

  assert_no_start_when_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> !$past(done));

  assert_no_start_zero_count_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> ($past(count) != '0));

endmodule

bind dma_channel dma_channel_chk #(.AW(AW), .DW(DW), .CW(CW), .RAW(RAW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .m_valid   (m_valid),
  .m_ready   (m_ready),
  .m_write   (m_write),
  .m_addr    (m_addr),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .en        (en),
  .done      (done),
  .pbase     (pbase),
  .mbase     (mbase),
  .count     (count_cfg)
);

// File: tb/dma_channel_tb.sv
module dma_channel_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        per_req = 1'b0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic        m_write;
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic [31:0] m_wdata;
  logic        m_rsp_valid = 1'b0;
  logic [31:0] m_rsp_data = '0;
  logic        irq;

  always #5 clk = ~clk;

  dma_channel u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_req(per_req),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
    .m_size(m_size), .m_wdata(m_wdata), .m_rsp_valid(m_rsp_valid),
    .m_rsp_data(m_rsp_data), .irq(irq)
  );

  int vecs = 0;
  int errs = 0;

  // behavioural model state
  bit          md_en = 0, md_done = 0, md_busy = 0;
  logic [6:0]  md_cfg = '0;   // control bits 7:1
  logic [31:0] md_pb = '0, md_mb = '0, md_pc = '0, md_mc = '0;
  logic [15:0] md_cnt = '0, md_rem = '0;
  logic [31:0] last_rd = '0;
  int          rsp_cd = 0;

  // stimulus controls
  bit          per_drive = 0, per_rand = 0;
  bit          rd_req = 0, wr_req = 0;
  logic [2:0]  rd_a = '0, wr_a = '0;
  logic [31:0] wr_d = '0;
  string       rd_tag = "";
  logic [15:0] lfsr = 16'hACE1;
  bit          prev_valid = 0, prev_per = 0, prev_en = 0;
  bit          watch_idle = 0;

  function automatic logic [31:0] fdat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h0000_5A5A;
  endfunction

  function automatic logic [31:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return {24'd0, md_cfg, md_en};
      3'd1: return {31'd0, md_done};
      3'd2: return md_pb;
      3'd3: return md_mb;
      3'd4: return {16'd0, md_cnt};
      3'd5: return {16'd0, md_rem};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    bit hr, hw, st, fin;
    bit n_en, n_done;
    logic [6:0]  n_cfg;
    logic [31:0] n_pb, n_mb, n_pc, n_mc, stp, src, dst;
    logic [15:0] n_cnt, n_rem;
    @(posedge clk); #1;
    check(irq === (md_done & md_cfg[6]), "R8 irq level", {31'd0, irq}, {31'd0, md_done & md_cfg[6]});
    if (watch_idle) check(m_valid === 1'b0, "R12 no request", {31'd0, m_valid}, 32'd0);
    cfg_we = 1'b0;
    if (rd_req) begin
      cfg_addr = rd_a; #1;
      check(cfg_rdata === model_rd(rd_a), rd_tag, cfg_rdata, model_rd(rd_a));
      rd_req = 0;
    end
    if (wr_req) begin
      cfg_we = 1'b1; cfg_addr = wr_a; cfg_wdata = wr_d; wr_req = 0;
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = lfsr[0] | lfsr[3];
    if (per_rand) per_drive = lfsr[7];
    per_req = per_drive;
    m_rsp_valid = 1'b0;
    if (rsp_cd > 0) begin
      rsp_cd--;
      if (rsp_cd == 0) begin m_rsp_valid = 1'b1; m_rsp_data = fdat(last_rd); end
    end
    #1;
    if (m_valid && !m_write && !prev_valid)
      check(prev_per && prev_en, "R3 start paced by request", {30'd0, prev_per, prev_en}, 32'd3);
    prev_valid = m_valid; prev_per = per_req; prev_en = md_en;

    hr  = m_valid && m_ready && !m_write;
    hw  = m_valid && m_ready && m_write;
    stp = 32'd1 << md_cfg[3:2];
    src = md_cfg[5] ? md_mc : md_pc;
    dst = md_cfg[5] ? md_pc : md_mc;
    if (hr) begin
      check(m_addr === src, "R4 source address", m_addr, src);
      check(m_size === md_cfg[3:2], "R5 size code", {30'd0, m_size}, {30'd0, md_cfg[3:2]});
      last_rd = m_addr; rsp_cd = 1 + int'(lfsr[5]); md_busy = 1;
    end
    if (hw) begin
      check(m_addr === dst, "R4 destination address", m_addr, dst);
      check(m_wdata === fdat(last_rd), "R3 write data", m_wdata, fdat(last_rd));
    end
    n_en = md_en; n_done = md_done; n_cfg = md_cfg; n_pb = md_pb; n_mb = md_mb;
    n_cnt = md_cnt; n_pc = md_pc; n_mc = md_mc; n_rem = md_rem; st = 0;
    if (cfg_we) begin
      case (cfg_addr)
        3'd0: if (!md_en) begin
                n_cfg = cfg_wdata[7:1];
                if (cfg_wdata[0] && !md_done && md_cnt != 0) begin n_en = 1; st = 1; end
              end else if (!cfg_wdata[0]) n_en = 0;
        3'd1: if (cfg_wdata[0]) n_done = 0;
        3'd2: if (!md_en) n_pb = cfg_wdata;
        3'd3: if (!md_en) n_mb = cfg_wdata;
        3'd4: if (!md_en) n_cnt = cfg_wdata[15:0];
        default: ;
      endcase
    end
    if (hw) begin
      md_busy = 0;
      fin = (md_rem == 16'd1);
      if (md_cfg[0]) n_pc = md_pc + stp;
      if (md_cfg[1]) n_mc = md_mc + stp;
      n_rem = md_rem - 16'd1;
      if (fin) begin
        n_done = 1;
        if (md_cfg[4]) begin n_pc = md_pb; n_mc = md_mb; n_rem = md_cnt; end
        else n_en = 0;
      end
    end
    if (st) begin n_pc = md_pb; n_mc = md_mb; n_rem = md_cnt; end
    md_en = n_en; md_done = n_done; md_cfg = n_cfg; md_pb = n_pb; md_mb = n_mb;
    md_cnt = n_cnt; md_pc = n_pc; md_mc = n_mc; md_rem = n_rem;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    rd_req = 1; rd_a = a; rd_tag = tag; cyc();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_req = 1; wr_a = a; wr_d = d; cyc();
  endtask

  task automatic run_idle(input int maxc);
    int n = 0;
    while ((md_en || md_busy) && n < maxc) begin cyc(); n++; end
    check(!md_en && !md_busy, "R6 transfer finished in time", {31'd0, md_en}, 32'd0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #1_500_000;
    errs++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) cyc();
    // R1 reset state
    for (int a = 0; a < 6; a++) rd(3'(a), "R1 reset register");
    check(m_valid === 1'b0, "R1 no request after reset", {31'd0, m_valid}, 32'd0);

    // R2 R5 R6 R8: periph -> mem, halfword, mem increments, interrupt on
    wr(3'd2, 32'h0000_1000);
    wr(3'd3, 32'h0000_2000);
    wr(3'd4, 32'd4);
    rd(3'd2, "R2 peripheral base readback");
    rd(3'd3, "R2 memory base readback");
    rd(3'd4, "R2 count readback");
    per_drive = 1;
    wr(3'd0, 32'h0000_008D);   // irq_en, size 1, mem_inc, run
    rd(3'd0, "R2 control readback");
    rd(3'd5, "R2 remaining loaded");
    run_idle(400);
    rd(3'd1, "R6 completion flag");
    rd(3'd0, "R6 run bit cleared");
    rd(3'd5, "R6 nothing remaining");

    // R10 enable ignored while flag set; R9 clear
    wr(3'd0, 32'h0000_008D);
    rd(3'd0, "R10 run refused while flagged");
    wr(3'd1, 32'd1);
    rd(3'd1, "R9 flag cleared by write one");

    // R4 R5 R11: mem -> periph, word, periph increments, paced request
    wr(3'd2, 32'h0000_8000);
    wr(3'd3, 32'h0000_9100);
    wr(3'd4, 32'd3);
    per_rand = 1;
    wr(3'd0, 32'h0000_0053);   // dir, size 2, per_inc, run
    wr(3'd2, 32'hDEAD_0000);
    rd(3'd2, "R11 base write ignored while running");
    wr(3'd0, 32'h0000_00FB);   // run kept set: field changes ignored
    rd(3'd0, "R11 control fields locked");
    run_idle(600);
    per_rand = 0;
    rd(3'd1, "R6 flag after second job");
    wr(3'd1, 32'd1);

    // R7 R9: circular, byte size, both increment, clear on every cycle
    wr(3'd2, 32'h0000_3000);
    wr(3'd3, 32'h0000_4001);
    wr(3'd4, 32'd2);
    per_drive = 1;
    wr(3'd0, 32'h0000_00A7);   // irq_en, circ, size 0, both inc, run
    for (int i = 0; i < 60; i++) wr(3'd1, 32'd1);
    rd(3'd0, "R7 still running after laps");
    rd(3'd5, "R7 remaining after laps");
    wr(3'd0, 32'h0000_00A6);   // stop
    rd(3'd0, "R11 stop write clears run");
    run_idle(100);
    rd(3'd1, "R9 flag state after stop");
    wr(3'd1, 32'd1);

    // R12 zero count
    wr(3'd4, 32'd0);
    wr(3'd0, 32'h0000_0087);
    watch_idle = 1;
    rd(3'd0, "R12 run refused with zero count");
    repeat (20) cyc();
    watch_idle = 0;
    rd(3'd1, "R12 flag stays clear");
    summary();
  end

endmodule